// File: doc/BRIEF.md
# Power-Up Strap Latch and Pad Switchover Sequencer

This block manages three dual-purpose pads. Right after reset each pad is read as a configuration strap set by a board resistor. The block waits a short programmable delay, then reads the strap levels every cycle. It captures them once two consecutive reads match. The captured value stays fixed until the next reset.

Capture starts a settling timer that counts reference-clock cycles. The default count of 28636 equals about 2 ms at 14.318 MHz. When the timer expires, the pad drivers may turn on. Pads 0 and 1 then repeat the reference clock. Pad 2 carries a rate clock, either the 48 MHz or the 24 MHz source, as chosen by the strap captured on pad 0.

The strap on pad 1 selects spread spectrum. The strap on pad 2 is a global output enable that gates every driver. The block never enables a pad driver before the timer expires, so it cannot fight a strap resistor during power-up.

Top module: `strap_boot_seq`

## Requirements
- R1: While reset is held, `pad_oe` and `pad_out` are all zero, and `straps_valid` and `settle_done` are low.
- R2: After reset, straps are captured only when two consecutive cycle reads of `pad_in` are equal. While the pad levels differ on every cycle, `straps_valid` stays low. Once the levels are stable, it rises within a few cycles of the sampling delay.
- R3: After capture, changes on `pad_in` have no effect until the next reset. `rate_24m`, `spread_en`, `outputs_enable` and the pad outputs keep their values.
- R4: `settle_done` rises exactly SETTLE_CYCLES clock cycles after `straps_valid` rises. It then stays high until reset.
- R5: While `settle_done` is low, no pad is driven: `pad_oe` is 3'b000 and `pad_out` is 3'b000.
- R6: The rate strap is `pad_in[0]`. When it is captured low, `rate_24m` is 0 and pad 2 carries `src_48`. When it is captured high, `rate_24m` is 1 and pad 2 carries `src_24`.
- R7: The spread strap is `pad_in[1]`. When it is captured low, `spread_en` is 1. When it is captured high, `spread_en` is 0. `spread_en` is 0 before capture.
- R8: The enable strap is `pad_in[2]`. If it is captured high, then after `settle_done` `pad_oe` is 3'b111 and `outputs_enable` is 1. If it is captured low, `pad_oe`, `pad_out` and `outputs_enable` stay 0.
- R9: After `settle_done`, with the enable strap high, pads 0 and 1 both carry `src_ref`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that clocks the sequencer |
| rst_n | input | 1 | Active-low reset (power-up) |
| pad_in | input | 3 | Levels seen on the three pads (strap inputs) |
| src_ref | input | 1 | Reference clock copy routed to pads 0 and 1 |
| src_48 | input | 1 | 48 MHz source for pad 2 |
| src_24 | input | 1 | 24 MHz source for pad 2 |
| pad_out | output | 3 | Pad output data |
| pad_oe | output | 3 | Pad driver enables, 1 = driving |
| rate_24m | output | 1 | Captured rate selection, 1 = 24 MHz |
| spread_en | output | 1 | Spread spectrum enabled |
| outputs_enable | output | 1 | Global enable for all clock outputs |
| straps_valid | output | 1 | Straps have been captured |
| settle_done | output | 1 | Settling timer expired, pads switched over |

## Verification
The bench builds the block with SETTLE_CYCLES at 50 and SAMPLE_DELAY at 3. With these values, the full timer expiry and the switchover are reached in every trial, so the exact count from capture to `settle_done` can be measured against the parameter.

All eight strap combinations are run in directed trials, along with random patterns. Some trials toggle the pads on every cycle through the sampling window to exercise the agreement filter. Others change the pads after capture to show that the captured straps are held.

// File: rtl/strap_pkg.sv
package strap_pkg;
   localparam int NUM_PADS   = 3;
   localparam int PAD_RATE   = 0;
   localparam int PAD_SPREAD = 1;
   localparam int PAD_OE     = 2;

   typedef enum logic [1:0] {
      PH_HOLD    = 2'd0,
      PH_SAMPLE  = 2'd1,
      PH_LATCHED = 2'd2
   } filt_phase_e;
endpackage

// File: rtl/strap_filter.sv
module strap_filter
   import strap_pkg::*;
#(
   parameter int W     = 3,
   parameter int DELAY = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] strap_in,
   output logic [W-1:0] latched,
   output logic         valid
);
   localparam int DW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("strap_filter: DELAY must be at least 1");
      end
      if (W < 1) begin : g_bad_width
         $error("strap_filter: W must be at least 1");
      end
   endgenerate

   filt_phase_e   phase;
   logic [DW-1:0] dly;
   logic [W-1:0]  prev;
   logic          have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_HOLD;
         dly       <= '0;
         prev      <= '0;
         have_prev <= 1'b0;
         latched   <= '0;
         valid     <= 1'b0;
      end else begin
         case (phase)
            PH_HOLD: begin
               if (dly == DW'(DELAY - 1)) phase <= PH_SAMPLE;
               else                       dly   <= dly + 1'b1;
            end
            PH_SAMPLE: begin
               prev      <= strap_in;
               have_prev <= 1'b1;
               if (have_prev && (strap_in == prev)) begin
                  latched <= strap_in;
                  valid   <= 1'b1;
                  phase   <= PH_LATCHED;
               end
            end
            default: ;
         endcase
      end
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(valid)) |-> $stable(latched)); // R3

   AST_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> ($past(strap_in) == latched && $past(strap_in, 2) == latched)); // R2
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int COUNT = 28636
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic done
);
   localparam int CW = $clog2(COUNT + 1);

   generate
      if (COUNT < 2) begin : g_bad_count
         $error("settle_timer: COUNT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (start && !done) begin
         if (cnt == CW'(COUNT - 1)) done <= 1'b1;
         else                       cnt  <= cnt + 1'b1;
      end
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done); // R4
endmodule

// File: rtl/pad_mux.sv
module pad_mux
   import strap_pkg::*;
#(
   parameter int W = NUM_PADS
) (
   input  logic         done,
   input  logic         oe_strap,
   input  logic         rate_24m,
   input  logic         src_ref,
   input  logic         src_48,
   input  logic         src_24,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out
);
   generate
      if (W != NUM_PADS) begin : g_bad_width
         $error("pad_mux: W must equal NUM_PADS");
      end
   endgenerate

   logic drive;
   assign drive = done & oe_strap;

   for (genvar g = 0; g < W; g++) begin : g_pad
      logic src;
      if (g == PAD_OE) begin : g_rate
         assign src = rate_24m ? src_24 : src_48;
      end else begin : g_ref
         assign src = src_ref;
      end
      assign pad_oe[g]  = drive;
      assign pad_out[g] = drive & src;
   end

   always_comb begin
      AST_NO_DRIVE_EARLY: assert (done || (pad_oe == '0 && pad_out == '0)); // R5
      AST_GLOBAL_OFF: assert (oe_strap || pad_oe == '0); // R8
   end
endmodule

// File: rtl/strap_boot_seq.sv
module strap_boot_seq
   import strap_pkg::*;
#(
   parameter int SETTLE_CYCLES = 28636,
   parameter int SAMPLE_DELAY  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] pad_in,
   input  logic       src_ref,
   input  logic       src_48,
   input  logic       src_24,
   output logic [2:0] pad_out,
   output logic [2:0] pad_oe,
   output logic       rate_24m,
   output logic       spread_en,
   output logic       outputs_enable,
   output logic       straps_valid,
   output logic       settle_done
);
   logic [NUM_PADS-1:0] straps;

   strap_filter #(.W(NUM_PADS), .DELAY(SAMPLE_DELAY)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_in (pad_in),
      .latched  (straps),
      .valid    (straps_valid)
   );

   settle_timer #(.COUNT(SETTLE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (straps_valid),
      .done  (settle_done)
   );

   assign rate_24m       = straps[PAD_RATE];
   assign spread_en      = straps_valid & ~straps[PAD_SPREAD];
   assign outputs_enable = settle_done & straps[PAD_OE];

   pad_mux #(.W(NUM_PADS)) u_mux (
      .done     (settle_done),
      .oe_strap (straps[PAD_OE]),
      .rate_24m (rate_24m),
      .src_ref  (src_ref),
      .src_48   (src_48),
      .src_24   (src_24),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out)
   );

   AST_DONE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      settle_done |-> straps_valid); // R4

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      straps_valid |=> straps_valid); // R3
endmodule

// File: tb/strap_boot_seq_bench.sv
module strap_boot_seq_bench;
   localparam int SETTLE = 50;
   localparam int DELAY  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] pad_in = 3'b000;
   logic       src_ref = 1'b1, src_48 = 1'b1, src_24 = 1'b1;
   logic [2:0] pad_out, pad_oe;
   logic       rate_24m, spread_en, outputs_enable, straps_valid, settle_done;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   always #5 clk = ~clk;

   strap_boot_seq #(.SETTLE_CYCLES(SETTLE), .SAMPLE_DELAY(DELAY)) u_strap_boot_seq (
      .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
      .src_ref(src_ref), .src_48(src_48), .src_24(src_24),
      .pad_out(pad_out), .pad_oe(pad_oe), .rate_24m(rate_24m),
      .spread_en(spread_en), .outputs_enable(outputs_enable),
      .straps_valid(straps_valid), .settle_done(settle_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_out(input logic [2:0] s, input logic r, input logic f48,
                                          input logic f24);
      if (!s[2]) return 3'b000;
      return {(s[0] ? f24 : f48), r, r};
   endfunction

   task automatic run_trial(input logic [2:0] s, input bit glitch);
      int n;
      rst_n   = 1'b0;
      pad_in  = s;
      {src_ref, src_48, src_24} = 3'b111;
      repeat (3) @(negedge clk);
      chk("R1 pad_oe", {29'd0, pad_oe}, 32'd0);
      chk("R1 pad_out", {29'd0, pad_out}, 32'd0);
      chk("R1 valid/done", {30'd0, straps_valid, settle_done}, 32'd0);
      rst_n = 1'b1;
      if (glitch) begin
         for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            chk("R2 no capture while toggling", {31'd0, straps_valid}, 32'd0);
            pad_in = (i % 2 == 1) ? s : ~s;
         end
         pad_in = s;
      end
      n = 0;
      while (!straps_valid && n < 40) begin
         @(negedge clk);
         n++;
      end
      chk("R2 capture", {31'd0, straps_valid}, 32'd1);
      chk("R6 rate_24m", {31'd0, rate_24m}, {31'd0, s[0]});
      chk("R7 spread_en", {31'd0, spread_en}, {31'd0, ~s[1]});
      n = 0;
      while (!settle_done && n < SETTLE + 10) begin
         chk("R5 pad_oe before done", {29'd0, pad_oe}, 32'd0);
         chk("R5 pad_out before done", {29'd0, pad_out}, 32'd0);
         @(negedge clk);
         n++;
      end
      chk("R4 settle count", n, SETTLE);
      for (int k = 0; k < 4; k++) begin
         {src_ref, src_48, src_24} = 3'($urandom);
         #1;
         chk("R8 pad_oe", {29'd0, pad_oe}, s[2] ? 32'd7 : 32'd0);
         chk("R8 outputs_enable", {31'd0, outputs_enable}, {31'd0, s[2]});
         chk("R9 ref pads", {30'd0, pad_out[1:0]}, {30'd0, exp_out(s, src_ref, src_48, src_24)[1:0]});
         chk("R6 rate pad", {31'd0, pad_out[2]}, {31'd0, exp_out(s, src_ref, src_48, src_24)[2]});
      end
      pad_in = ~s;
      repeat (6) @(negedge clk);
      chk("R3 rate held", {31'd0, rate_24m}, {31'd0, s[0]});
      chk("R3 spread held", {31'd0, spread_en}, {31'd0, ~s[1]});
      chk("R3 enable held", {31'd0, outputs_enable}, {31'd0, s[2]});
      chk("R3 flags held", {30'd0, straps_valid, settle_done}, 32'd3);
      chk("R3 pads held", {29'd0, pad_out}, {29'd0, exp_out(s, src_ref, src_48, src_24)});
      chk("R4 done sticky", {31'd0, settle_done}, 32'd1);
   endtask

   initial begin
      void'($urandom(32'h5eed_0137));
      for (int p = 0; p < 8; p++) run_trial(3'(p), (p % 3) == 1);
      for (int t = 0; t < 4; t++) run_trial(3'($urandom), ($urandom % 2) == 1);
      run_trial(3'b111, 1'b1);
      run_trial(3'b000, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule